// File: doc/BRIEF.md
# ECC-Protected Scratchpad Controller with Byte Read-Modify-Write

This block sits in front of a local data RAM. Each 16-bit half-word is stored as a 22-bit codeword: 16 data bits plus a 6-bit single-error-correct, double-error-detect Hamming code. A request port accepts half-word writes, byte writes and half-word reads. A half-word write encodes its data and stores it straight away. A byte write cannot do that, because the untouched byte is needed to form the check bits. The controller therefore reads the half-word, merges in the new byte and writes the result back with fresh check bits. Reads correct any single-bit error before they return data. An uncorrectable error sets sticky status flags, captures the byte address of the faulting access and sends a one-cycle trap request to the core. Because the core may take that trap several instructions later, the captured address is what identifies the cause.

After reset the array holds arbitrary contents, and a read of such a location is uncorrectable. This includes the hidden read inside a byte write. Software can clear the array with half-word writes. Alternatively, when `cfg_hw_init` is high at reset, a built-in sequencer writes zero data with valid check bits to every word, one word per cycle, while the request port is stalled.

Request handshake: a request moves on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the controller is idle and initialisation is finished. A requester that sees `req_ready` low keeps its request stable. Read data goes out on a valid/ready response port. `rsp_valid` and `rsp_rdata` hold until `rsp_ready` is seen high at a clock edge, and no new request is accepted while a response is pending. Writes produce no response.

Top module: `ecc_spad_ctrl`

## Requirements
- R1: A write with `req_be`=2'b11 stores the half-word at word `req_addr[AW-1:1]` without reading the array, and `req_ready` stays high in the next cycle. A later read of that word returns the data. `rsp_valid` rises on the second clock edge after a read is accepted.
- R2: A write with exactly one byte enable (`req_be`=2'b01 writes bits 7:0, 2'b10 writes bits 15:8, taken from the same lanes of `req_wdata`) replaces only that byte and keeps the other byte. `req_ready` is low for exactly the one cycle after acceptance.
- R3: `err_inject` is XORed into the 22-bit codeword stored by the write it travels with. One flipped bit is corrected on read, with no flag change and no trap.
- R4: An uncorrectable read (two flipped bits) sets `err_detected`, `err_in_spad` and `err_dual` and loads `err_addr` with the request byte address. `trap_req` pulses for one cycle, in the same cycle `rsp_valid` rises.
- R5: If the read inside a byte write is uncorrectable, the error is reported as in R4 and the word is left unwritten, so a later read of it is still uncorrectable.
- R6: While `err_detected` is set, later uncorrectable errors still pulse `trap_req` but change neither the flags nor `err_addr`.
- R7: `err_clear` clears the three flags and keeps `err_addr`. If a new uncorrectable error occurs on the same edge, the new error is captured.
- R8: Between a read response being offered and being accepted, `rsp_valid` and `rsp_rdata` stay stable and `req_ready` stays low.
- R9: If `cfg_hw_init` is low, `init_done` rises after the first clock edge following reset, and any location not yet written reads as uncorrectable. If it is high, `init_done` and `req_ready` stay low until edge DEPTH+1 after reset, after which every word reads as zero without error.
- R10: A write with `req_be`=2'b00 is accepted and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hw_init | input | 1 | Run the hardware clearing sequence after reset |
| init_done | output | 1 | Controller ready for traffic |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_be | input | 2 | Byte enables of a write |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Requester takes read data |
| rsp_rdata | output | 16 | Corrected read data |
| err_inject | input | 22 | Codeword bit flips applied to the write |
| err_clear | input | 1 | Clear the error flags |
| err_detected | output | 1 | Integrity error captured |
| err_in_spad | output | 1 | Captured error lies in this scratchpad |
| err_dual | output | 1 | Captured error was a dual-bit error |
| err_addr | output | AW | Byte address of the captured error |
| trap_req | output | 1 | One-cycle integrity trap request |

## Verification
Two things can coincide here: an uncorrectable error being captured, and software clearing the flags on the same clock edge. The bench sets up this case by holding `err_clear` high during the cycle in which a read of an uninitialised word is decoded, while an older error is still latched. It expects the flags to stay set and `err_addr` to change to the new address. It also checks, in separate steps, that a clear on its own drops the flags and that a second error without a clear leaves the old address in place.

// File: rtl/ecc_spad_pkg.sv
package ecc_spad_pkg;

  localparam int DW = 16;   // data bits per word
  localparam int CW = 22;   // codeword bits: overall parity at 0, Hamming positions 1..21
  localparam int PW = 5;    // Hamming check bits

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_INIT,
    ST_IDLE,
    ST_RD,
    ST_RMW,
    ST_RSP
  } spad_state_e;

  // Positions covered by Hamming check bit b
  function automatic logic [CW-1:0] cover_mask(input int b);
    logic [CW-1:0] m;
    m = '0;
    for (int p = 1; p < CW; p++) begin
      m[p[4:0]] = (((p >> b) & 1) != 0);
    end
    return m;
  endfunction

  function automatic logic [CW-1:0] secded_encode(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    logic [4:0]    pos;
    int            k;
    c = '0;
    k = 0;
    for (int p = 1; p < CW; p++) begin
      if ((p & (p - 1)) != 0) begin
        c[p[4:0]] = d[k[3:0]];
        k++;
      end
    end
    for (int b = 0; b < PW; b++) begin
      pos    = 5'(1 << b);
      c[pos] = ^(c & cover_mask(b));
    end
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  function automatic logic [DW-1:0] secded_extract(input logic [CW-1:0] c);
    logic [DW-1:0] d;
    int            k;
    d = '0;
    k = 0;
    for (int p = 1; p < CW; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[k[3:0]] = c[p[4:0]];
        k++;
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/ecc_spad_array.sv
module ecc_spad_array #(
  parameter int          DEPTH = 64,
  parameter int          CW    = 22,
  parameter logic [21:0] PWRUP = 22'h000006,
  localparam int         IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [CW-1:0] wdata,
  input  logic          re,
  input  logic [IW-1:0] raddr,
  output logic [CW-1:0] rdata
);

  logic [CW-1:0] mem [DEPTH];

  // Reset loads a fixed pattern that stands for arbitrary power-up contents
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= PWRUP[CW-1:0];
      rdata <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/ecc_spad_dec.sv
module ecc_spad_dec
  import ecc_spad_pkg::*;
(
  input  logic [CW-1:0] cw_i,
  output logic [DW-1:0] data_o,
  output logic          sgl_o,
  output logic          dbl_o
);

  logic [PW-1:0] syn;
  logic          ovr;
  logic [CW-1:0] fixed;

  for (genvar b = 0; b < PW; b++) begin : g_syn
    assign syn[b] = ^(cw_i & cover_mask(b));
  end

  assign ovr = ^cw_i;

  always_comb begin
    fixed = cw_i;
    if (ovr && (syn < 5'(CW))) fixed[syn] = ~cw_i[syn];
  end

  assign sgl_o  = ovr && (syn < 5'(CW));
  assign dbl_o  = (!ovr && (syn != '0)) || (ovr && (syn >= 5'(CW)));
  assign data_o = secded_extract(fixed);

endmodule

// File: rtl/ecc_spad_errlog.sv
module ecc_spad_errlog #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  logic [AW-1:0] evt_addr,
  input  logic          clr,
  output logic          det,
  output logic          spad,
  output logic          dual,
  output logic [AW-1:0] addr,
  output logic          trap
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det  <= 1'b0;
      spad <= 1'b0;
      dual <= 1'b0;
      addr <= '0;
      trap <= 1'b0;
    end else begin
      trap <= evt;
      if (evt && (!det || clr)) begin
        det  <= 1'b1;
        spad <= 1'b1;
        dual <= 1'b1;
        addr <= evt_addr;
      end else if (clr) begin
        det  <= 1'b0;
        spad <= 1'b0;
        dual <= 1'b0;
      end
    end
  end

  AST_TRAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> !trap); // R4
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    det && !clr |=> $stable(addr) && det); // R6

endmodule

// File: rtl/ecc_spad_ctrl.sv
module ecc_spad_ctrl
  import ecc_spad_pkg::*;
#(
  parameter int          DEPTH = 64,
  parameter logic [21:0] PWRUP = 22'h000006,
  localparam int         IW    = $clog2(DEPTH),
  localparam int         AW    = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_hw_init,
  output logic          init_done,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_be,
  input  logic [15:0]   req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [15:0]   rsp_rdata,
  input  logic [21:0]   err_inject,
  input  logic          err_clear,
  output logic          err_detected,
  output logic          err_in_spad,
  output logic          err_dual,
  output logic [AW-1:0] err_addr,
  output logic          trap_req
);

  localparam logic [CW-1:0] ZERO_CW = secded_encode('0);

  spad_state_e   state;
  logic [IW-1:0] init_cnt;
  logic [AW-1:0] op_addr;
  logic          op_lane_lo;
  logic [DW-1:0] op_wdata;
  logic [CW-1:0] op_inj;
  logic [DW-1:0] rsp_q;

  logic          accept, is_byte, is_full;
  logic          mem_we, mem_re;
  logic [IW-1:0] mem_waddr, mem_raddr;
  logic [CW-1:0] mem_wdata, mem_rdata;
  logic [DW-1:0] dec_data, merged;
  logic          dec_sgl, dec_dbl, bad_evt;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign is_byte   = (req_be == 2'b01) || (req_be == 2'b10);
  assign is_full   = (req_be == 2'b11);
  assign rsp_valid = (state == ST_RSP);
  assign rsp_rdata = rsp_q;

  assign merged  = op_lane_lo ? {dec_data[15:8], op_wdata[7:0]}
                              : {op_wdata[15:8], dec_data[7:0]};
  assign bad_evt = ((state == ST_RD) || (state == ST_RMW)) && dec_dbl;

  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = req_addr[AW-1:1];
    mem_wdata = secded_encode(req_wdata) ^ err_inject;
    mem_re    = 1'b0;
    mem_raddr = req_addr[AW-1:1];
    unique case (state)
      ST_INIT: begin
        mem_we    = 1'b1;
        mem_waddr = init_cnt;
        mem_wdata = ZERO_CW;
      end
      ST_IDLE: begin
        mem_we = accept && req_write && is_full;
        mem_re = accept && (!req_write || is_byte);
      end
      ST_RMW: begin
        mem_we    = !dec_dbl;
        mem_waddr = op_addr[AW-1:1];
        mem_wdata = secded_encode(merged) ^ op_inj;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_BOOT;
      init_cnt   <= '0;
      init_done  <= 1'b0;
      op_addr    <= '0;
      op_lane_lo <= 1'b0;
      op_wdata   <= '0;
      op_inj     <= '0;
      rsp_q      <= '0;
    end else begin
      unique case (state)
        ST_BOOT: begin
          init_cnt <= '0;
          if (cfg_hw_init) state <= ST_INIT;
          else begin
            state     <= ST_IDLE;
            init_done <= 1'b1;
          end
        end
        ST_INIT: begin
          init_cnt <= init_cnt + 1'b1;
          if (init_cnt == IW'(DEPTH - 1)) begin
            state     <= ST_IDLE;
            init_done <= 1'b1;
          end
        end
        ST_IDLE: begin
          if (accept) begin
            op_addr    <= req_addr;
            op_lane_lo <= req_be[0];
            op_wdata   <= req_wdata;
            op_inj     <= err_inject;
            if (!req_write)   state <= ST_RD;
            else if (is_byte) state <= ST_RMW;
          end
        end
        ST_RD: begin
          rsp_q <= dec_data;
          state <= ST_RSP;
        end
        ST_RMW: state <= ST_IDLE;
        ST_RSP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  ecc_spad_array #(.DEPTH(DEPTH), .CW(CW), .PWRUP(PWRUP)) i_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .re    (mem_re),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  ecc_spad_dec i_dec (
    .cw_i   (mem_rdata),
    .data_o (dec_data),
    .sgl_o  (dec_sgl),
    .dbl_o  (dec_dbl)
  );

  ecc_spad_errlog #(.AW(AW)) i_errlog (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (bad_evt),
    .evt_addr (op_addr),
    .clr      (err_clear),
    .det      (err_detected),
    .spad     (err_in_spad),
    .dual     (err_dual),
    .addr     (err_addr),
    .trap     (trap_req)
  );

  AST_READY_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> init_done); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R8
  AST_SGL_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RD) || (state == ST_RMW)) && dec_sgl |=> !trap_req); // R3

endmodule

// File: tb/test_ecc_spad_ctrl.sv
module test_ecc_spad_ctrl;

  localparam int DEPTH = 64;
  localparam int AW    = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_hw_init = 1'b0;
  logic          init_done;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_be = 2'b11;
  logic [15:0]   req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [15:0]   rsp_rdata;
  logic [21:0]   err_inject = '0;
  logic          err_clear = 1'b0;
  logic          err_detected, err_in_spad, err_dual;
  logic [AW-1:0] err_addr;
  logic          trap_req;

  always #10 clk = ~clk;

  ecc_spad_ctrl #(.DEPTH(DEPTH)) i_ecc_spad_ctrl (.*);

  int n_chk = 0;
  int n_err = 0;

  // Reference model: per-word data and error level (0 clean, 1 single, 2 uncorrectable)
  logic [15:0]   m_data [DEPTH];
  int            m_err  [DEPTH];
  logic          e_det, e_spad, e_dual, e_trap;
  logic [AW-1:0] e_addr;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Advance one cycle and compare the status outputs with the model
  task automatic tick();
    @(negedge clk);
    chk(err_detected == e_det, "R4 detected flag", err_detected, e_det);
    chk(err_in_spad == e_spad, "R4 location flag", err_in_spad, e_spad);
    chk(err_dual == e_dual, "R4 dual flag", err_dual, e_dual);
    chk(err_addr == e_addr, "R6 error address", err_addr, e_addr);
    chk(trap_req == e_trap, "R4 trap pulse", trap_req, e_trap);
    e_trap = 1'b0;
  endtask

  task automatic model_error(input int a, input bit clr_now);
    if (!e_det || clr_now) begin
      e_det = 1'b1; e_spad = 1'b1; e_dual = 1'b1; e_addr = AW'(a);
    end
    e_trap = 1'b1;
  endtask

  task automatic rd(input int a, input int hold, input bit clr_now);
    int w;
    logic [15:0] first;
    w = a >> 1;
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a); req_be = 2'b11;
    while (!req_ready) tick();
    tick();
    req_valid = 1'b0;
    err_clear = clr_now;
    if (m_err[w] >= 2) model_error(a, clr_now);
    else if (clr_now) begin e_det = 1'b0; e_spad = 1'b0; e_dual = 1'b0; end
    tick();
    err_clear = 1'b0;
    chk(rsp_valid == 1'b1, "R1 response latency", rsp_valid, 1);
    if (m_err[w] < 2) chk(rsp_rdata == m_data[w], "R1 R3 read data", rsp_rdata, m_data[w]);
    first = rsp_rdata;
    for (int i = 0; i < hold; i++) begin
      tick();
      chk(rsp_valid == 1'b1, "R8 valid held", rsp_valid, 1);
      chk(rsp_rdata == first, "R8 data held", rsp_rdata, first);
      chk(req_ready == 1'b0, "R8 no new request", req_ready, 0);
    end
    rsp_ready = 1'b1;
    tick();
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0, "R8 response taken", rsp_valid, 0);
    chk(req_ready == 1'b1, "R8 ready again", req_ready, 1);
  endtask

  task automatic wr(input int a, input logic [1:0] be, input logic [15:0] wd, input logic [21:0] inj);
    int w;
    w = a >> 1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_be = be; req_wdata = wd;
    err_inject = inj;
    while (!req_ready) tick();
    tick();
    req_valid = 1'b0;
    err_inject = '0;
    if (be == 2'b11) begin
      m_data[w] = wd;
      m_err[w]  = $countones(inj);
      chk(req_ready == 1'b1, "R1 full write no stall", req_ready, 1);
    end else if (be == 2'b00) begin
      chk(req_ready == 1'b1, "R10 empty write no stall", req_ready, 1);
    end else begin
      chk(req_ready == 1'b0, "R2 byte write stall", req_ready, 0);
      if (m_err[w] >= 2) model_error(a, 1'b0);
      else begin
        if (be[0]) m_data[w][7:0]  = wd[7:0];
        else       m_data[w][15:8] = wd[15:8];
        m_err[w] = $countones(inj);
      end
      tick();
      chk(req_ready == 1'b1, "R2 byte write done", req_ready, 1);
    end
  endtask

  task automatic clr();
    err_clear = 1'b1;
    e_det = 1'b0; e_spad = 1'b0; e_dual = 1'b0;
    tick();
    err_clear = 1'b0;
  endtask

  task automatic do_reset(input bit hw);
    @(negedge clk);
    rst_n = 1'b0; cfg_hw_init = hw;
    req_valid = 1'b0; rsp_ready = 1'b0; err_clear = 1'b0; err_inject = '0;
    @(negedge clk);
    chk(init_done == 1'b0, "R9 reset done", init_done, 0);
    chk(req_ready == 1'b0, "R9 reset ready", req_ready, 0);
    chk(rsp_valid == 1'b0, "R8 reset valid", rsp_valid, 0);
    chk(err_detected == 1'b0, "R4 reset flag", err_detected, 0);
    chk(trap_req == 1'b0, "R4 reset trap", trap_req, 0);
    for (int i = 0; i < DEPTH; i++) begin m_data[i] = '0; m_err[i] = 2; end
    e_det = 0; e_spad = 0; e_dual = 0; e_trap = 0; e_addr = '0;
    rst_n = 1'b1;
    if (hw) begin
      for (int n = 1; n <= DEPTH + 1; n++) begin
        tick();
        if (n == DEPTH) begin
          chk(init_done == 1'b0, "R9 init still running", init_done, 0);
          chk(req_ready == 1'b0, "R9 stall during init", req_ready, 0);
        end
      end
      chk(init_done == 1'b1, "R9 init done", init_done, 1);
      chk(req_ready == 1'b1, "R9 ready after init", req_ready, 1);
      for (int i = 0; i < DEPTH; i++) m_err[i] = 0;
    end else begin
      tick();
      chk(init_done == 1'b1, "R9 done without init", init_done, 1);
      chk(req_ready == 1'b1, "R9 ready without init", req_ready, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired R1 actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    // Run without hardware initialisation
    do_reset(1'b0);
    rd(16'h10, 0, 1'b0);                 // R4 R9: uninitialised word
    rd(16'h20, 1, 1'b0);                 // R6: second error keeps first address
    clr();                               // R7
    wr(16'h30, 2'b01, 16'h00EE, '0);     // R5: byte write over garbage
    clr();
    rd(16'h30, 0, 1'b0);                 // R5: still uncorrectable
    clr();
    wr(16'h40, 2'b11, 16'hA5C3, '0);     // R1
    wr(16'h42, 2'b11, 16'h1234, '0);
    wr(16'h44, 2'b11, 16'hFFFF, '0);
    rd(16'h40, 0, 1'b0);
    rd(16'h42, 3, 1'b0);                 // R8 back-pressure
    rd(16'h44, 2, 1'b0);
    wr(16'h40, 2'b10, 16'h7700, '0);     // R2 upper byte
    wr(16'h43, 2'b01, 16'h0056, '0);     // R2 lower byte, odd address
    rd(16'h40, 0, 1'b0);
    rd(16'h42, 0, 1'b0);
    wr(16'h50, 2'b11, 16'hBEEF, 22'h000080); // R3 single flip in data
    wr(16'h52, 2'b11, 16'h0F0F, 22'h000001); // R3 single flip in parity
    rd(16'h50, 1, 1'b0);
    rd(16'h52, 0, 1'b0);
    wr(16'h50, 2'b01, 16'h0011, '0);     // R2 R3 byte write over corrected word
    rd(16'h50, 0, 1'b0);
    wr(16'h54, 2'b11, 16'h4444, 22'h000300); // R4 double flip
    rd(16'h54, 0, 1'b0);
    rd(16'h22, 0, 1'b1);                 // R7 clear and new error on one edge
    clr();
    wr(16'h40, 2'b00, 16'hFFFF, '0);     // R10
    rd(16'h40, 0, 1'b0);
    // Run with hardware initialisation
    do_reset(1'b1);
    rd(16'h20, 0, 1'b0);                 // R9 zero after init
    wr(16'h30, 2'b10, 16'hAB00, '0);     // R2 byte write on initialised word
    rd(16'h30, 0, 1'b0);
    tick();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule